// File: doc/BRIEF.md
# Flash Payload Locator

This block is a boot-time sequencer. It finds the first byte of an application payload in a serial flash whose first contents are an FPGA configuration image. It talks to the flash through a byte-exchange port. The block raises a request with a byte to send, and a controller answers with a one-cycle acknowledge that carries the byte received. An active-low chip-select output frames each flash transaction.

After a start pulse, the block opens the flash at address zero with a read command and a three-byte address. It then clocks out dummy bytes until it sees the raw sync value. It discards a fixed-size header. It gathers a 32-bit length that counts bits and is stored with every byte bit-reversed, least significant byte first. It rounds that length up to a byte offset.

The block then waits for the controller's transmitter to drain, releases chip-select, and reopens the flash at the offset. Finally it raises done. The flash is left selected, so a later stage can stream the payload with further dummy exchanges.

Top module: `flash_payload_locator`

## Requirements
- R1: While reset is active and just after it, `cs_n` is 1, `xfer_req` is 0 and `done` is 0.
- R2: An open asserts `cs_n` low. The first exchange sends the read command 0x03. The next three exchanges send the 24-bit address, most significant byte first. Bytes received during these four exchanges are discarded, even when they equal the sync value.
- R3: `xfer_req` is raised only while `cs_n` is low. Once raised, it stays high with `xfer_tx` unchanged until the cycle in which `xfer_ack` is sampled high.
- R4: Every exchange after the address bytes sends 0x00.
- R5: The first open uses address 0. Scanning discards data bytes until a raw byte equal to 0x56 arrives. Other values, including 0xA6, never match.
- R6: The four data bytes that follow the sync byte are skipped whatever their values, including 0x56.
- R7: The next four data bytes form a 32-bit bit count, least significant byte first. Each byte is bit-reversed (bit i moves to bit 7-i) before it is placed.
- R8: The byte offset is (bit_count + 7) >> 3, computed without overflow, and truncated to its low 24 bits.
- R9: Chip-select is released only in a cycle after `tx_empty` was sampled high. The flash is then reopened once, with 0x03 and the byte offset as address. Each run performs exactly two opens.
- R10: Done rises once the reopen address has been sent. While done is high and no start arrives, `done` and `offset` hold, `cs_n` stays low and no exchange is issued.
- R11: A start pulse while a run is in progress is ignored. A start in the idle or done state clears done. Starting from done, the block first closes the flash and then reruns from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a search |
| xfer_req | output | 1 | Exchange request to the serial controller |
| xfer_tx | output | 8 | Byte to send, valid while `xfer_req` is high |
| xfer_ack | input | 1 | One-cycle exchange completion |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| tx_empty | input | 1 | Controller transmitter has drained |
| cs_n | output | 1 | Flash chip-select, active low |
| done | output | 1 | Payload offset found and flash reopened there |
| offset | output | 24 | Payload byte offset, valid while `done` is high |

## Verification
The checker watches the handshake on every cycle. It confirms that a request holds its byte until acknowledged, that requests occur only while selected, and that chip-select rises only after the transmitter reported empty. It also confirms that done freezes the offset and silences the port. What only the bench scenarios can show is the content side. That covers the read command and address sequence of both opens, rejection of sync-like bytes in the command, address and header positions, the bit-reversed little-endian assembly, and the rounding across a sweep of lengths that includes the 32-bit extremes, under several acknowledge latencies and drain delays.

// File: rtl/flp_pkg.sv
package flp_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CMD_READ = 8'h03;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_OPEN,
      ST_CMD,
      ST_ADDR,
      ST_SCAN,
      ST_SKIP,
      ST_LEN,
      ST_CALC,
      ST_CLOSE,
      ST_FIN
   } flp_state_e;

endpackage

// File: rtl/flp_bitrev.sv
module flp_bitrev #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/flp_len_acc.sv
module flp_len_acc #(
   parameter int unsigned LEN_BYTES = 4,
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned IDX_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] byte_off
);
   localparam int unsigned LEN_W = 8 * LEN_BYTES;

   if (LEN_W < ADDR_W + 3) begin : g_bad_width
      $error("flp_len_acc: length field too narrow for address width");
   end

   logic [7:0]       rev_byte;
   logic [LEN_W-1:0] len_w;
   logic [LEN_W:0]   rounded;

   flp_bitrev #(.W(8)) u_rev (
      .din  (byte_in),
      .dout (rev_byte)
   );

   for (genvar g = 0; g < LEN_BYTES; g++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 lane_q <= '0;
         else if (clr)                               lane_q <= '0;
         else if (wr && (idx == IDX_W'(g)))          lane_q <= rev_byte;
      end
      assign len_w[g*8 +: 8] = lane_q;
   end

   assign rounded  = {1'b0, len_w} + (LEN_W+1)'(7);
   assign byte_off = rounded[3 +: ADDR_W];
endmodule

// File: rtl/flash_payload_locator.sv
module flash_payload_locator
   import flp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned LEN_BYTES  = 4,
   parameter int unsigned SKIP_BYTES = 4,
   parameter logic [7:0]  SYNC_BYTE  = 8'h56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              xfer_req,
   output logic [7:0]        xfer_tx,
   input  logic              xfer_ack,
   input  logic [7:0]        xfer_rx,
   input  logic              tx_empty,
   output logic              cs_n,
   output logic              done,
   output logic [ADDR_W-1:0] offset
);
   localparam int unsigned ADDR_BYTES = ADDR_W / 8;
   localparam int unsigned MAX_A      = (ADDR_BYTES > SKIP_BYTES) ? ADDR_BYTES : SKIP_BYTES;
   localparam int unsigned MAX_CNT    = (MAX_A > LEN_BYTES) ? MAX_A : LEN_BYTES;
   localparam int unsigned CNT_W      = $clog2(MAX_CNT + 1);

   if ((ADDR_W % 8) != 0 || ADDR_W == 0) begin : g_bad_addr
      $error("flash_payload_locator: ADDR_W must be a nonzero multiple of 8");
   end
   if (SKIP_BYTES == 0 || LEN_BYTES == 0) begin : g_bad_counts
      $error("flash_payload_locator: SKIP_BYTES and LEN_BYTES must be nonzero");
   end

   flp_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic              req_q;
   logic [7:0]        tx_q;
   logic [7:0]        tx_next;
   logic              cs_n_q;
   logic              done_q;
   logic              reopen_q;
   logic [ADDR_W-1:0] off_q;
   logic [ADDR_W-1:0] sh_q;
   logic [ADDR_W-1:0] len_off;
   logic              fire;
   logic              accept;

   assign fire   = req_q && xfer_ack;
   assign accept = start && (st == ST_IDLE || st == ST_FIN);

   always_comb begin
      case (st)
         ST_CMD:  tx_next = CMD_READ;
         ST_ADDR: tx_next = sh_q[ADDR_W-1 -: 8];
         default: tx_next = 8'h00;
      endcase
   end

   flp_len_acc #(
      .LEN_BYTES (LEN_BYTES),
      .ADDR_W    (ADDR_W),
      .IDX_W     (CNT_W)
   ) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .wr       (fire && (st == ST_LEN)),
      .idx      (cnt),
      .byte_in  (xfer_rx),
      .byte_off (len_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         req_q    <= 1'b0;
         tx_q     <= '0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         reopen_q <= 1'b0;
         off_q    <= '0;
         sh_q     <= '0;
      end else begin
         case (st)
            ST_IDLE, ST_FIN: begin
               if (start) begin
                  done_q   <= 1'b0;
                  reopen_q <= 1'b0;
                  sh_q     <= '0;
                  st       <= (st == ST_IDLE) ? ST_OPEN : ST_CLOSE;
               end
            end
            ST_OPEN: begin
               cs_n_q <= 1'b0;
               st     <= ST_CMD;
            end
            ST_CALC: begin
               off_q    <= len_off;
               sh_q     <= len_off;
               reopen_q <= 1'b1;
               st       <= ST_CLOSE;
            end
            ST_CLOSE: begin
               if (tx_empty) begin
                  cs_n_q <= 1'b1;
                  st     <= ST_OPEN;
               end
            end
            default: begin
               if (!req_q) begin
                  req_q <= 1'b1;
                  tx_q  <= tx_next;
               end else if (xfer_ack) begin
                  req_q <= 1'b0;
                  case (st)
                     ST_CMD: begin
                        cnt <= '0;
                        st  <= ST_ADDR;
                     end
                     ST_ADDR: begin
                        sh_q <= sh_q << 8;
                        if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
                           cnt <= '0;
                           if (reopen_q) begin
                              done_q <= 1'b1;
                              st     <= ST_FIN;
                           end else begin
                              st <= ST_SCAN;
                           end
                        end else begin
                           cnt <= cnt + 1'b1;
                        end
                     end
                     ST_SCAN: begin
                        if (xfer_rx == SYNC_BYTE) begin
                           cnt <= '0;
                           st  <= ST_SKIP;
                        end
                     end
                     ST_SKIP: begin
                        if (cnt == CNT_W'(SKIP_BYTES - 1)) begin
                           cnt <= '0;
                           st  <= ST_LEN;
                        end else begin
                           cnt <= cnt + 1'b1;
                        end
                     end
                     ST_LEN: begin
                        if (cnt == CNT_W'(LEN_BYTES - 1)) begin
                           cnt <= '0;
                           st  <= ST_CALC;
                        end else begin
                           cnt <= cnt + 1'b1;
                        end
                     end
                     default: st <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   assign xfer_req = req_q;
   assign xfer_tx  = tx_q;
   assign cs_n     = cs_n_q;
   assign done     = done_q;
   assign offset   = off_q;
endmodule

// File: rtl/flp_checker.sv
module flp_checker #(
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              xfer_req,
   input logic [7:0]        xfer_tx,
   input logic              xfer_ack,
   input logic              tx_empty,
   input logic              cs_n,
   input logic              done,
   input logic [ADDR_W-1:0] offset
);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

   // R3
   req_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !cs_n);

   // R9
   cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(tx_empty));

   // R10
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!xfer_req && !cs_n));

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(offset)));
endmodule

bind flash_payload_locator flp_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .xfer_req (xfer_req),
   .xfer_tx  (xfer_tx),
   .xfer_ack (xfer_ack),
   .tx_empty (tx_empty),
   .cs_n     (cs_n),
   .done     (done),
   .offset   (offset)
);

// File: tb/flash_payload_locator_bench.sv
`timescale 1ns/1ps
module flash_payload_locator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        xfer_req;
   logic [7:0]  xfer_tx;
   logic        xfer_ack;
   logic [7:0]  xfer_rx;
   logic        tx_empty;
   logic        cs_n;
   logic        done;
   logic [23:0] offset;

   always #10 clk = ~clk;

   flash_payload_locator u_flash_payload_locator (
      .clk(clk), .rst_n(rst_n), .start(start),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .tx_empty(tx_empty), .cs_n(cs_n), .done(done), .offset(offset)
   );

   int checks = 0;
   int errors = 0;

   // scenario parameters
   int          sp = 0;
   logic [31:0] ln = '0;
   int          lat = 0;
   int          hold = 0;
   logic        clr_stats = 1'b0;

   function automatic logic [7:0] rev8(logic [7:0] b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = b[7-i];
      return r;
   endfunction

   function automatic logic [7:0] memb(int a);
      if (a < sp) return (a % 3 == 0) ? 8'hA6 : 8'hFF;
      if (a == sp) return 8'h56;
      if (a <= sp + 4) return 8'h56;
      if (a <= sp + 8) return rev8(ln[(a-sp-5)*8 +: 8]);
      return 8'(a) ^ 8'h5A;
   endfunction

   // flash + controller model
   int          lcnt, idx, te, nopen, nz, after, viol;
   logic [7:0]  cmd_cur;
   logic [23:0] a_acc, a_base;
   logic [7:0]  op_cmd [2];
   logic [23:0] op_addr [2];
   logic        prev_cs, prev_te;

   assign tx_empty = (te == 0);

   always @(posedge clk) begin
      if (!rst_n) begin
         xfer_ack <= 1'b0; xfer_rx <= '0; lcnt <= 0; idx <= 0; te <= 0;
         nopen <= 0; nz <= 0; after <= 0; a_acc <= '0; a_base <= '0; cmd_cur <= '0;
      end else begin
         if (clr_stats) begin nopen <= 0; nz <= 0; after <= 0; end
         if (xfer_ack) begin
            xfer_ack <= 1'b0;
            if (te != 0) te <= te - 1;
         end else if (xfer_req) begin
            if (lcnt >= lat) begin
               xfer_ack <= 1'b1;
               lcnt     <= 0;
               te       <= hold;
               idx      <= idx + 1;
               if (done) after <= after + 1;
               if (idx == 0) begin
                  cmd_cur <= xfer_tx; xfer_rx <= 8'h56;
               end else if (idx <= 3) begin
                  a_acc   <= {a_acc[15:0], xfer_tx};
                  xfer_rx <= 8'h56;
                  if (idx == 3) begin
                     a_base <= {a_acc[15:0], xfer_tx};
                     if (nopen < 2) begin
                        op_cmd[nopen]  <= cmd_cur;
                        op_addr[nopen] <= {a_acc[15:0], xfer_tx};
                     end
                     nopen <= nopen + 1;
                  end
               end else begin
                  xfer_rx <= memb(int'(a_base) + idx - 4);
                  if (xfer_tx != 8'h00) nz <= nz + 1;
               end
            end else begin
               lcnt <= lcnt + 1;
               if (te != 0) te <= te - 1;
            end
         end else if (te != 0) begin
            te <= te - 1;
         end
         if (cs_n) idx <= 0;
      end
   end

   always @(negedge clk) begin
      if (!rst_n || clr_stats) viol <= 0;
      else if (cs_n && !prev_cs && !prev_te) viol <= viol + 1;
      prev_cs <= cs_n;
      prev_te <= tx_empty;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run(int s, logic [31:0] l, int lt, int hd, bit poke);
      logic [32:0] t;
      logic [23:0] exp_off;
      logic [23:0] held;
      bit          seen;
      sp = s; ln = l; lat = lt; hold = hd;
      t = {1'b0, l} + 33'd7;
      exp_off = t[26:3];
      @(negedge clk) clr_stats = 1'b1;
      @(negedge clk) begin clr_stats = 1'b0; start = 1'b1; end
      @(negedge clk) start = 1'b0;
      chk("R11 done cleared by start", 32'(done), 32'd0);
      seen = 1'b0;
      for (int c = 0; c < 40000; c++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
         start = (poke && c == 25);
      end
      start = 1'b0;
      if (!seen) begin
         checks++; errors++;
         $display("FAIL R10 watchdog: actual done=0 expected done=1");
      end
      chk("R10 done", 32'(done), 32'd1);
      chk("R6/R7/R8 offset", 32'(offset), 32'(exp_off));
      chk("R9 open count", 32'(nopen), 32'd2);
      chk("R2 first command", 32'(op_cmd[0]), 32'h03);
      chk("R5 first address", 32'(op_addr[0]), 32'd0);
      chk("R9 reopen command", 32'(op_cmd[1]), 32'h03);
      chk("R9 reopen address", 32'(op_addr[1]), 32'(exp_off));
      chk("R4 dummy bytes zero", 32'(nz), 32'd0);
      chk("R9 release after drain", 32'(viol), 32'd0);
      held = offset;
      repeat (8) @(negedge clk);
      chk("R10 held done", 32'(done), 32'd1);
      chk("R10 held offset", 32'(offset), 32'(held));
      chk("R10 flash kept selected", 32'(cs_n), 32'd0);
      chk("R10 no exchange after done", 32'(after), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk("R1 cs_n in reset", 32'(cs_n), 32'd1);
      chk("R1 req in reset", 32'(xfer_req), 32'd0);
      chk("R1 done in reset", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cs_n after reset", 32'(cs_n), 32'd1);
      // directed corners, then a sweep of small lengths
      run(0, 32'd0,          0, 0, 1'b0);
      run(5, 32'd1,          1, 2, 1'b0);
      run(10, 32'd8,         2, 0, 1'b1);  // R11 start while busy
      run(3, 32'd9,          0, 3, 1'b0);
      run(20, 32'h7FFFFFF8,  1, 1, 1'b1);
      run(7, 32'hFFFFFFFF,   0, 0, 1'b0);
      run(1, 32'h00012345,   3, 2, 1'b0);
      run(2, 32'h5A3C0F81,   1, 4, 1'b0);
      for (int k = 0; k < 18; k++) run(k % 5, 32'(k), k % 3, k % 4, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule